// File: doc/BRIEF.md
# Dual Performance Counter Unit

This block watches a small fixed set of per-cycle event sources and accumulates chosen events into two programmable 40-bit counters. Each counter has its own 32-bit event-select register. That register chooses an event code and a unit mask, and it can turn the per-cycle increment into a single-count threshold test. The test can be inverted and can be limited to rising edges. A single run bit in select register 0 starts and stops both counters together. A counter is silenced on its own by giving it an event that counts nothing.

Software reaches the four registers through a plain read/write port. Counters are usually preloaded with a negative value so that they overflow after a chosen number of events. On that overflow a sticky per-counter flag can be raised toward the interrupt controller.

There are eight event sources, numbered 0 to 7, with codes 0x79, 0xC0, 0x2E, 0x28, 0x29, 0xC1, 0x10 and 0x11 in that order. Sources 2, 3 and 4 are cache-request sources. Each of them carries four line-state bits: bit 0 is M, bit 1 is E, bit 2 is S and bit 3 is I. Every other source carries a 4-bit increment amount.

Top module: `pmu_dual_counter`

## Requirements
- R1: Address 0 is select 0, address 1 is select 1, address 2 is counter 0 and address 3 is counter 1. A select reads back the low 32 bits of its last write with bits 63:32 at zero. A counter reads back its 40-bit value zero-extended to 64 bits. Read data is combinational on the address.
- R2: A counter write stores bits 31:0 of the write data, and bits 39:32 become copies of bit 31. Write-data bits 63:32 are ignored.
- R3: Counting happens only while bit 22 of select 0 is 1, and this applies to both counters. Bit 22 of select 1 has no effect.
- R4: Select bits 7:0 hold the event code. For a non-cache source whose code matches, the counter adds that source's increment when the threshold field is zero. A code that matches no source counts nothing.
- R5: For a cache-request code, unit-mask bits 11:8 pick the M, E, S and I states, and the increment is the number of picked states present in that cycle. If those four mask bits are zero, nothing counts; code 0x2E with a zero mask is the idle setting.
- R6: Codes 0xC1, 0x10 and 0x14 count only on counter 0. Codes 0x11, 0x12 and 0x13 count only on counter 1. On the other counter they count nothing under any option.
- R7: When threshold bits 31:24 are non-zero, the counter adds 1 in a cycle where the increment is at least the threshold. When invert (bit 23) is set, it adds 1 when the increment is below the threshold instead. In both cases it adds at most 1 per cycle.
- R8: With edge bit 18 set and a non-zero threshold, the counter adds 1 only in a cycle where the threshold condition is true and was false in the previous cycle. The previous-cycle condition is tracked every clock, whether or not counting is enabled.
- R9: A carry out of counter bit 39 sets that counter's sticky flag on `irq_o` only if bit 20 of its own select is set. A counter write clears the flag. A counter write also takes precedence over counting in the same cycle.
- R10: Reset clears both selects, both counters and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| evt_inc | input | NSRC*INC_W | Per-source increment amount, 4 bits per source |
| evt_state | input | NSRC*4 | Per-source line-state bits (M,E,S,I in bits 0..3 of each nibble) |
| irq_o | output | 2 | Sticky overflow flags, bit i for counter i |

## Verification
The checker assumes that a write strobe lasts one cycle and that register contents change only through writes. It also assumes the threshold field is compared against a bounded increment, so a counter with a non-zero threshold moves by at most one per cycle. The bench writes registers one at a time and keeps the event inputs at zero during the write sequences. Between writes it drives increments and line states from a shift-register generator over the full 4-bit range, so that every threshold from 0 to 4 is crossed in both directions. Counter preloads in the sweep start at zero, so overflow occurs only in the dedicated wrap test.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int NUM_CTR = 2;
    localparam int SEL_W   = 32;
    localparam int RD_W    = 64;
    localparam int LS_W    = 4;     // line-state qualifier bits per source

    // select-register field positions
    localparam int B_EDGE  = 18;
    localparam int B_INTEN = 20;
    localparam int B_EN    = 22;
    localparam int B_INV   = 23;

    localparam logic [1:0] A_SEL0 = 2'd0;
    localparam logic [1:0] A_CTR0 = 2'd2;

    // fixed event code carried by each source slot
    function automatic logic [7:0] src_code(input int k);
        case (k)
            0: return 8'h79;
            1: return 8'hC0;
            2: return 8'h2E;
            3: return 8'h28;
            4: return 8'h29;
            5: return 8'hC1;
            6: return 8'h10;
            7: return 8'h11;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic src_is_cache(input int k);
        return (k >= 2) && (k <= 4);
    endfunction

    // counter placement restrictions
    function automatic logic code_allowed(input logic [7:0] code, input int idx);
        case (code)
            8'hC1, 8'h10, 8'h14: return idx == 0;
            8'h11, 8'h12, 8'h13: return idx == 1;
            default:             return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/pmu_evt_filter.sv
module pmu_evt_filter
    import pmu_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int INC_W   = 4,
    parameter int CTR_IDX = 0
) (
    input  logic [SEL_W-1:0]        sel,
    input  logic [NSRC*INC_W-1:0]   evt_inc,
    input  logic [NSRC*LS_W-1:0]    evt_state,
    input  logic                    prev_cond,
    output logic [INC_W-1:0]        add,
    output logic                    cond
);
    logic [7:0]       code, umask, cmask;
    logic             inv, edg, hit, cache, valid, thr;
    logic [INC_W-1:0] raw;
    logic             unused_sel;

    assign code  = sel[7:0];
    assign umask = sel[15:8];
    assign cmask = sel[31:24];
    assign inv   = sel[B_INV];
    assign edg   = sel[B_EDGE];
    assign unused_sel = ^{sel[22:19], sel[17:16], umask[7:4]};

    always_comb begin
        hit   = 1'b0;
        cache = 1'b0;
        raw   = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (src_code(k) == code) begin
                hit   = 1'b1;
                cache = src_is_cache(k);
                raw   = cache ? INC_W'($countones(evt_state[k*LS_W +: LS_W] & umask[3:0]))
                              : evt_inc[k*INC_W +: INC_W];
            end
        end
        valid = hit && code_allowed(code, CTR_IDX) && !(cache && umask[3:0] == 4'd0);
        thr   = inv ? (32'(raw) <  32'(cmask))
                    : (32'(raw) >= 32'(cmask));
        cond  = valid && thr;
        if (!valid)
            add = '0;
        else if (cmask == 8'd0)
            add = raw;
        else
            add = INC_W'(edg ? (cond && !prev_cond) : cond);
    end
endmodule

// File: rtl/pmu_ctr_step.sv
module pmu_ctr_step #(
    parameter int CTR_W = 40,
    parameter int INC_W = 4
) (
    input  logic [CTR_W-1:0] cur,
    input  logic             load,
    input  logic [31:0]      wval,
    input  logic             count_en,
    input  logic [INC_W-1:0] add,
    input  logic             irq_cur,
    input  logic             int_en,
    output logic [CTR_W-1:0] nxt,
    output logic             irq_nxt
);
    localparam int EXT_W = CTR_W - 32;

    logic [CTR_W:0] sum;

    always_comb begin
        sum     = {1'b0, cur} + (CTR_W+1)'(add);
        nxt     = cur;
        irq_nxt = irq_cur;
        if (load) begin
            nxt     = {{EXT_W{wval[31]}}, wval};
            irq_nxt = 1'b0;
        end else if (count_en) begin
            nxt     = sum[CTR_W-1:0];
            irq_nxt = irq_cur | (sum[CTR_W] & int_en);
        end
    end
endmodule

// File: rtl/pmu_dual_counter.sv
module pmu_dual_counter
    import pmu_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int INC_W = 4,
    parameter int CTR_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              reg_addr,
    input  logic                    reg_wr,
    input  logic [RD_W-1:0]         reg_wdata,
    output logic [RD_W-1:0]         reg_rdata,
    input  logic [NSRC*INC_W-1:0]   evt_inc,
    input  logic [NSRC*LS_W-1:0]    evt_state,
    output logic [NUM_CTR-1:0]      irq_o
);
    typedef struct packed {
        logic [NUM_CTR-1:0][SEL_W-1:0] sel;
        logic [NUM_CTR-1:0][CTR_W-1:0] ctr;
        logic [NUM_CTR-1:0]            irq;
        logic [NUM_CTR-1:0]            prev;
    } state_t;

    state_t s_q, s_d;

    logic [NUM_CTR-1:0][INC_W-1:0] add_w;
    logic [NUM_CTR-1:0]            cond_w;
    logic [NUM_CTR-1:0][CTR_W-1:0] ctr_nx;
    logic [NUM_CTR-1:0]            irq_nx;
    logic                          run;
    logic                          unused_hi;

    assign run       = s_q.sel[0][B_EN];
    assign unused_hi = ^reg_wdata[RD_W-1:32];

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            pmu_evt_filter #(
                .NSRC(NSRC), .INC_W(INC_W), .CTR_IDX(i)
            ) u_flt (
                .sel(s_q.sel[i]), .evt_inc(evt_inc), .evt_state(evt_state),
                .prev_cond(s_q.prev[i]), .add(add_w[i]), .cond(cond_w[i])
            );
            pmu_ctr_step #(
                .CTR_W(CTR_W), .INC_W(INC_W)
            ) u_step (
                .cur(s_q.ctr[i]),
                .load(reg_wr && (reg_addr == A_CTR0 + 2'(i))),
                .wval(reg_wdata[31:0]), .count_en(run), .add(add_w[i]),
                .irq_cur(s_q.irq[i]), .int_en(s_q.sel[i][B_INTEN]),
                .nxt(ctr_nx[i]), .irq_nxt(irq_nx[i])
            );
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_wr && reg_addr == A_SEL0 + 2'(i))
                s_d.sel[i] = reg_wdata[SEL_W-1:0];
            s_d.ctr[i]  = ctr_nx[i];
            s_d.irq[i]  = irq_nx[i];
            s_d.prev[i] = cond_w[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = RD_W'(s_q.sel[0]);
            2'd1:    reg_rdata = RD_W'(s_q.sel[1]);
            2'd2:    reg_rdata = RD_W'(s_q.ctr[0]);
            default: reg_rdata = RD_W'(s_q.ctr[1]);
        endcase
    end

    assign irq_o = s_q.irq;
endmodule

// File: rtl/pmu_dual_counter_chk.sv
module pmu_dual_counter_chk #(
    parameter int CTR_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      sel0_q,
    input logic [31:0]      sel1_q,
    input logic [CTR_W-1:0] ctr0_q,
    input logic [CTR_W-1:0] ctr1_q,
    input logic [1:0]       irq_o
);
    assert_load_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=>
        (ctr0_q == {{(CTR_W-32){$past(reg_wdata[31])}}, $past(reg_wdata)}));

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel0_q[22] && !reg_wr) |=> ($stable(ctr0_q) && $stable(ctr1_q)));

    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0_q[31:24] != 8'd0 && !reg_wr) |=>
        (CTR_W'(ctr0_q - $past(ctr0_q)) <= CTR_W'(1)));

    assert_irq0_needs_inten_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[0]) |-> $past(sel0_q[20]));

    assert_irq1_needs_inten_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[1]) |-> $past(sel1_q[20]));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o[0] && !(reg_wr && reg_addr == 2'd2)) |=> irq_o[0]);

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3) |=> !irq_o[1]);
endmodule

bind pmu_dual_counter pmu_dual_counter_chk #(.CTR_W(CTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata[31:0]), .sel0_q(s_q.sel[0]), .sel1_q(s_q.sel[1]),
    .ctr0_q(s_q.ctr[0]), .ctr1_q(s_q.ctr[1]), .irq_o(irq_o)
);

// File: tb/pmu_dual_counter_tb.sv
module pmu_dual_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [31:0] evt_inc = '0;
    logic [31:0] evt_state = '0;
    logic [1:0]  irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [1:0][31:0] m_sel;
    logic [1:0][39:0] m_ctr;
    logic [1:0]       m_irq;
    logic [1:0]       m_prev;
    logic [31:0]      lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;

    pmu_dual_counter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .evt_inc(evt_inc), .evt_state(evt_state), .irq_o(irq_o)
    );

    function automatic logic [7:0] bcode(input int k);
        case (k)
            0: return 8'h79; 1: return 8'hC0; 2: return 8'h2E; 3: return 8'h28;
            4: return 8'h29; 5: return 8'hC1; 6: return 8'h10; default: return 8'h11;
        endcase
    endfunction

    function automatic logic [63:0] mksel(input logic [7:0] code, input logic [7:0] um,
            input logic edg, input logic inten, input logic en, input logic inv,
            input logic [7:0] cm);
        return 64'({cm, inv, en, 1'b0, inten, 1'b0, edg, 2'b00, um, code});
    endfunction

    function automatic void m_eval(input int i, output logic [3:0] add, output logic cond);
        logic [7:0] code, um, cm;
        logic hit, cache, ok, valid, thr;
        logic [3:0] raw;
        code = m_sel[i][7:0]; um = m_sel[i][15:8]; cm = m_sel[i][31:24];
        hit = 0; cache = 0; raw = 0;
        for (int k = 0; k < 8; k++) begin
            if (bcode(k) == code) begin
                hit = 1;
                cache = (k >= 2 && k <= 4);
                raw = cache ? 4'($countones(evt_state[4*k +: 4] & um[3:0])) : evt_inc[4*k +: 4];
            end
        end
        ok = 1;
        if ((code == 8'hC1 || code == 8'h10 || code == 8'h14) && i != 0) ok = 0;
        if ((code == 8'h11 || code == 8'h12 || code == 8'h13) && i != 1) ok = 0;
        valid = hit && ok && !(cache && um[3:0] == 4'd0);
        thr = m_sel[i][23] ? (raw < cm) : (raw >= cm);
        cond = valid && thr;
        if (!valid) add = 0;
        else if (cm == 0) add = raw;
        else add = (m_sel[i][18] ? (cond && !m_prev[i]) : cond) ? 4'd1 : 4'd0;
    endfunction

    task automatic tick();
        logic [1:0][3:0] a;
        logic [1:0] c;
        logic [40:0] sum;
        logic en;
        en = m_sel[0][22];
        for (int i = 0; i < 2; i++) m_eval(i, a[i], c[i]);
        for (int i = 0; i < 2; i++) begin
            if (wr && addr == 2'(2 + i)) begin
                m_ctr[i] = {{8{wdata[31]}}, wdata[31:0]};
                m_irq[i] = 0;
            end else if (en) begin
                sum = {1'b0, m_ctr[i]} + 41'(a[i]);
                m_ctr[i] = sum[39:0];
                if (sum[40] && m_sel[i][20]) m_irq[i] = 1;
            end
            m_prev[i] = c[i];
        end
        if (wr && addr < 2) m_sel[addr[0]] = wdata[31:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [63:0] d);
        addr = a; wdata = d; wr = 1;
        tick();
        wr = 0;
    endtask

    task automatic run(input int n, input bit rnd);
        for (int j = 0; j < n; j++) begin
            if (rnd) begin
                lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                evt_inc = lfsr;
                evt_state = {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_C3C3;
            end
            tick();
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_model(input string req);
        logic [63:0] v;
        rd(2'd2, v); chk(req, v, 64'(m_ctr[0]));
        rd(2'd3, v); chk(req, v, 64'(m_ctr[1]));
        chk(req, 64'(irq_o), 64'(m_irq));
    endtask

    function automatic logic [7:0] pair_code(input int p, input int w);
        case (p)
            0: return w == 0 ? 8'h79 : 8'hC0;
            1: return w == 0 ? 8'h2E : 8'h28;
            2: return w == 0 ? 8'h29 : 8'h2E;
            3: return w == 0 ? 8'hC1 : 8'h11;
            4: return w == 0 ? 8'h11 : 8'hC1;
            default: return w == 0 ? 8'h10 : 8'h55;
        endcase
    endfunction

    task automatic quiet_setup(input logic [63:0] s0, input logic [63:0] s1,
                               input logic [63:0] c0, input logic [63:0] c1);
        evt_inc = '0; evt_state = '0;
        wreg(2'd0, s0 & ~(64'h1 << 22));
        wreg(2'd2, c0);
        wreg(2'd3, c1);
        wreg(2'd1, s1);
        wreg(2'd0, s0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog R10: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        m_sel = '0; m_ctr = '0; m_irq = '0; m_prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R10: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R10 reset register", v, 64'h0);
        end
        chk("R10 reset irq", 64'(irq_o), 64'h0);

        // R1 / R2: readback and sign extension
        wreg(2'd1, 64'hDEAD_BEEF_A5C3_0F2E);
        wreg(2'd0, 64'hFFFF_FFFF_0012_3479);
        rd(2'd1, v); chk("R1 select 1 readback", v, 64'h0000_0000_A5C3_0F2E);
        rd(2'd0, v); chk("R1 select 0 readback", v, 64'h0000_0000_0012_3479);
        wreg(2'd2, 64'h1234_5678_8000_0001);
        wreg(2'd3, 64'h0000_0000_7FFF_FFFF);
        rd(2'd2, v); chk("R2 negative preload", v, 64'h0000_00FF_8000_0001);
        rd(2'd3, v); chk("R2 positive preload", v, 64'h0000_0000_7FFF_FFFF);

        // R3: enable bit only in select 0
        wreg(2'd0, mksel(8'h79, 8'h00, 0, 0, 0, 0, 8'h00));
        wreg(2'd1, mksel(8'h79, 8'h00, 0, 0, 1, 0, 8'h00));
        evt_inc = 32'hFFFF_FFFF;
        run(5, 0);
        rd(2'd3, v); chk("R3 select 1 enable ignored", v, 64'h0000_0000_7FFF_FFFF);
        chk_model("R3 idle model");

        // R4 R5 R6 R7 R8 sweep
        for (int p = 0; p < 6; p++)
            for (int cm = 0; cm < 5; cm++)
                for (int inv = 0; inv < 2; inv++)
                    for (int ed = 0; ed < 2; ed++) begin
                        logic [7:0] um;
                        um = (p % 2) ? 8'h0B : 8'h06;
                        quiet_setup(mksel(pair_code(p, 0), um, 1'(ed), 1, 1, 1'(inv), 8'(cm)),
                                    mksel(pair_code(p, 1), um, 1'(ed), 1, 0, 1'(inv), 8'(cm)),
                                    64'h0, 64'h0);
                        run(16, 1);
                        chk_model("R4 R5 R6 R7 R8 sweep");
                    end

        // R5: idle code and line-state popcount
        quiet_setup(mksel(8'h2E, 8'h00, 0, 0, 1, 0, 8'h00), mksel(8'h2E, 8'h00, 0, 0, 0, 1, 8'h01),
                    64'h0, 64'h0);
        evt_state = 32'hFFFF_FFFF; evt_inc = 32'hFFFF_FFFF;
        run(8, 0);
        rd(2'd2, v); chk("R5 idle code counter 0", v, 64'h0);
        rd(2'd3, v); chk("R5 idle code with invert", v, 64'h0);
        quiet_setup(mksel(8'h2E, 8'h05, 0, 0, 1, 0, 8'h00), 64'h0, 64'h0, 64'h0);
        evt_state = 32'h0000_0700;   // source 2 states M,E,S present
        run(4, 0);
        rd(2'd2, v); chk("R5 popcount of M and S", v, 64'd8);

        // R6: restricted code
        quiet_setup(mksel(8'h11, 8'h00, 0, 0, 1, 0, 8'h00), mksel(8'h11, 8'h00, 0, 0, 0, 0, 8'h00),
                    64'h0, 64'h0);
        evt_inc = 32'h3000_0000;     // source 7 increment 3
        run(4, 0);
        rd(2'd2, v); chk("R6 wrong counter", v, 64'h0);
        rd(2'd3, v); chk("R6 allowed counter", v, 64'd12);

        // R9: overflow, interrupt enable, sticky flag, write precedence
        quiet_setup(mksel(8'h79, 8'h00, 0, 1, 1, 0, 8'h00), mksel(8'hC0, 8'h00, 0, 0, 0, 0, 8'h00),
                    64'hFFFF_FFFD, 64'hFFFF_FFFD);
        evt_inc = 32'h0000_0011;
        run(2, 0);
        chk("R9 no flag before wrap", 64'(irq_o), 64'h0);
        run(1, 0);
        rd(2'd2, v); chk("R9 wrap to zero", v, 64'h0);
        chk("R9 flag only with interrupt enable", 64'(irq_o), 64'h1);
        run(2, 0);
        chk("R9 flag sticky", 64'(irq_o), 64'h1);
        wreg(2'd2, 64'h10);
        rd(2'd2, v); chk("R9 write wins over count", v, 64'h10);
        chk("R9 write clears flag", 64'(irq_o), 64'h0);
        chk_model("R9 model");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule